// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Macrocells

This block is a small field-configurable logic array. Each external input and each macrocell state bit is offered to a programmable AND plane in both true and inverted polarity. Every product term may include any of those literals or leave it out. A programmable OR plane then combines any chosen subset of the product terms into each output sum. Each output sum passes through a macrocell that holds a D flip-flop. The macrocell has a select that drives either the raw sum or the flip-flop state to the pin, and an enable that decides whether the pin is driven at all. The flip-flop state of every macrocell is fed back into the AND plane as an extra input, so the array can implement small state machines as well as plain combinational functions.

Configuration is loaded before operation through a one-bit serial shift path while a program signal is high. During programming the pins are not driven and the macrocell flip-flops are held cleared. Once the program signal drops, the loaded pattern stays fixed and the array evaluates its inputs every cycle.

Top module: `pla_array`

## Requirements
- R1: A synchronous active-high reset clears the whole configuration and every macrocell flip-flop, so after reset `pin_oe` and `pin_val` are all 0.
- R2: While `prog_en` is high, each rising clock edge shifts `cfg_din` into bit 0 of a CFG_LEN-bit configuration word and moves every other bit one place up, so a word sent most significant bit first is in place after CFG_LEN edges. Layout, with L = 2*(N_IN+N_OUT): bit t*L+j connects literal j to product term t; bit N_PT*L + o*N_PT + t adds term t to output o; bit N_PT*L + N_OUT*N_PT + 2*o is the register select of output o (1 = registered) and the bit above it is its enable.
- R3: A product term is the AND of its connected literals, where literal 2k is source k and literal 2k+1 is its inverse; source k is `data_in[k]` for k < N_IN and the flip-flop of output k-N_IN otherwise. A term with no literal connected is 0.
- R4: The sum of output o is the OR of the product terms selected for it in the OR plane.
- R5: With the select at 0 the pin shows the output sum in the same cycle; with the select at 1 it shows the flip-flop, which loads the sum on each rising edge while not programming, so it trails the sum by one cycle.
- R6: The feedback literals carry the flip-flop state, so a function of a feedback literal changes one cycle after the sum that feeds that flip-flop.
- R7: An output whose enable is 0 has `pin_oe` at 0 and `pin_val` at 0, while its flip-flop and feedback keep running.
- R8: While `prog_en` is high every `pin_oe` and `pin_val` bit is 0 regardless of `data_in`, and every macrocell flip-flop is cleared on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Array clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Program mode: shift configuration, pins off |
| cfg_din | input | 1 | Serial configuration data |
| data_in | input | N_IN | External logic inputs |
| pin_val | output | N_OUT | Output value, 0 when not driven |
| pin_oe | output | N_OUT | Output drive enable per pin |

## Verification
Two things share a cycle in this block: the macrocell flip-flop loading a new sum and the feedback literal presenting the old flip-flop state to the AND plane. The bench provokes this by routing one output's flip-flop into a second output's product term and stepping the inputs, then checks that the second output shows the previous input's function one edge after the change and the new one after the second edge. A second overlap is configuration shifting while inputs keep toggling; there the pins must stay silent and the flip-flops must come out of programming cleared.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Register select of a macrocell.
    typedef enum logic {
        MC_COMB = 1'b0,
        MC_REG  = 1'b1
    } mc_sel_e;

    // Per-output macrocell configuration; sel sits in the lower bit.
    typedef struct packed {
        logic    enable;
        mc_sel_e sel;
    } mc_cfg_t;

    localparam int MC_BITS = $bits(mc_cfg_t);

    // Literal indices of a source in the AND plane.
    function automatic int lit_true(input int src);
        return 2 * src;
    endfunction

    function automatic int lit_inv(input int src);
        return 2 * src + 1;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (shift_en)
            cfg_q <= {cfg_q[LEN-2:0], din};
    end

    // R2: the serial bit lands in the lowest position on each shift edge.
    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (cfg_q[0] == $past(din)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_LIT = 10,
    parameter int N_PT  = 4
) (
    input  logic [N_LIT-1:0]      lits,
    input  logic [N_PT*N_LIT-1:0] and_cfg,
    output logic [N_PT-1:0]       terms
);

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [N_LIT-1:0] mask;
        assign mask = and_cfg[t*N_LIT +: N_LIT];
        // A literal that is not connected must not pull the term low.
        assign terms[t] = (|mask) & (&(lits | ~mask));

        // R3: an unprogrammed term never asserts.
        always_comb begin
            if (mask == '0)
                a_r3_empty_term: assert (terms[t] == 1'b0);
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT  = 4,
    parameter int N_OUT = 2
) (
    input  logic [N_PT-1:0]       terms,
    input  logic [N_OUT*N_PT-1:0] or_cfg,
    output logic [N_OUT-1:0]      sums
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sums[o] = |(terms & or_cfg[o*N_PT +: N_PT]);
    end

endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
    import pla_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_clr,
    input  logic    sum,
    input  mc_cfg_t mcfg,
    output logic    q,
    output logic    pin_val,
    output logic    pin_oe
);

    logic sel_val;

    always_ff @(posedge clk) begin
        if (rst || hold_clr)
            q <= 1'b0;
        else
            q <= sum;
    end

    assign sel_val = (mcfg.sel == MC_REG) ? q : sum;
    assign pin_oe  = mcfg.enable & ~hold_clr;
    assign pin_val = pin_oe & sel_val;

    // R5: in operation the flip-flop follows the sum with one cycle of delay.
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        !hold_clr |=> (q == $past(sum)));

    // R8: programming leaves the flip-flop cleared.
    a_r8_hold_clear: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> (q == 1'b0));

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_PT  = 4,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  data_in,
    output logic [N_OUT-1:0] pin_val,
    output logic [N_OUT-1:0] pin_oe
);

    localparam int N_SRC    = N_IN + N_OUT;
    localparam int N_LIT    = 2 * N_SRC;
    localparam int AND_BITS = N_PT * N_LIT;
    localparam int OR_BITS  = N_OUT * N_PT;
    localparam int MC_OFS   = AND_BITS + OR_BITS;
    localparam int CFG_LEN  = MC_OFS + N_OUT * MC_BITS;

    logic [CFG_LEN-1:0] cfg_q;
    logic [N_SRC-1:0]   src;
    logic [N_LIT-1:0]   lits;
    logic [N_PT-1:0]    terms;
    logic [N_OUT-1:0]   sums;
    logic [N_OUT-1:0]   fb_q;

    pla_cfg_chain #(
        .LEN(CFG_LEN)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .shift_en(prog_en),
        .din     (cfg_din),
        .cfg_q   (cfg_q)
    );

    // Sources: external inputs first, then macrocell feedback.
    assign src = {fb_q, data_in};

    for (genvar k = 0; k < N_SRC; k++) begin : g_lit
        assign lits[lit_true(k)] = src[k];
        assign lits[lit_inv(k)]  = ~src[k];
    end

    pla_and_plane #(
        .N_LIT(N_LIT),
        .N_PT (N_PT)
    ) u_and (
        .lits   (lits),
        .and_cfg(cfg_q[AND_BITS-1:0]),
        .terms  (terms)
    );

    pla_or_plane #(
        .N_PT (N_PT),
        .N_OUT(N_OUT)
    ) u_or (
        .terms (terms),
        .or_cfg(cfg_q[AND_BITS +: OR_BITS]),
        .sums  (sums)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_mc
        mc_cfg_t mcfg;
        assign mcfg = mc_cfg_t'(cfg_q[MC_OFS + o*MC_BITS +: MC_BITS]);

        pla_macrocell u_mc (
            .clk     (clk),
            .rst     (rst),
            .hold_clr(prog_en),
            .sum     (sums[o]),
            .mcfg    (mcfg),
            .q       (fb_q[o]),
            .pin_val (pin_val[o]),
            .pin_oe  (pin_oe[o])
        );
    end

    // R8: nothing is driven while the configuration is shifting.
    a_r8_prog_silent: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> ((pin_oe == '0) && (pin_val == '0)));

    // R7: a value only appears on a pin that is enabled.
    a_r7_val_needs_oe: assert property (@(posedge clk) disable iff (rst)
        ((pin_val & ~pin_oe) == '0));

endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;

    localparam int N_IN     = 3;
    localparam int N_PT     = 4;
    localparam int N_OUT    = 2;
    localparam int N_LIT    = 2 * (N_IN + N_OUT);
    localparam int AND_BITS = N_PT * N_LIT;
    localparam int OR_BITS  = N_OUT * N_PT;
    localparam int MC_OFS   = AND_BITS + OR_BITS;
    localparam int CFG_LEN  = MC_OFS + 2 * N_OUT;
    localparam logic [7:0] FMASK = 8'h75; // minterms 0,2,4,5,6

    logic             clk = 1'b0;
    logic             rst;
    logic             prog_en;
    logic             cfg_din;
    logic [N_IN-1:0]  data_in;
    logic [N_OUT-1:0] pin_val;
    logic [N_OUT-1:0] pin_oe;

    logic [CFG_LEN-1:0] cfg_v;
    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pla_array #(
        .N_IN (N_IN),
        .N_PT (N_PT),
        .N_OUT(N_OUT)
    ) u0 (
        .clk    (clk),
        .rst    (rst),
        .prog_en(prog_en),
        .cfg_din(cfg_din),
        .data_in(data_in),
        .pin_val(pin_val),
        .pin_oe (pin_oe)
    );

    function automatic logic fref(input int m);
        return FMASK[m];
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic set_lit(input int t, input int l);
        cfg_v[t*N_LIT + l] = 1'b1;
    endtask

    task automatic set_or(input int o, input int t);
        cfg_v[AND_BITS + o*N_PT + t] = 1'b1;
    endtask

    task automatic set_mc(input int o, input logic sel, input logic en);
        cfg_v[MC_OFS + 2*o]     = sel;
        cfg_v[MC_OFS + 2*o + 1] = en;
    endtask

    // Base function: P0 = ~x3 (data_in[0] inverted), P1 = x1 & ~x2,
    // P2 = feedback of output 0, P3 left empty.
    task automatic base_cfg();
        cfg_v = '0;
        set_lit(0, 1);
        set_lit(1, 4);
        set_lit(1, 3);
        set_lit(2, 2*N_IN);
        set_or(0, 0);
        set_or(0, 1);
    endtask

    // R2, R8: shift MSB first while inputs keep toggling; pins must stay off.
    task automatic load_cfg();
        for (int i = CFG_LEN - 1; i >= 0; i--) begin
            prog_en = 1'b1;
            cfg_din = cfg_v[i];
            data_in = N_IN'(i);
            @(posedge clk); #1;
            if (i % 13 == 0) begin
                check("R8 oe during programming", 4'(pin_oe), 4'h0);
                check("R8 val during programming", 4'(pin_val), 4'h0);
            end
        end
        prog_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; prog_en = 1'b0; cfg_din = 1'b0; data_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset oe", 4'(pin_oe), 4'h0);
        check("R1 reset val", 4'(pin_val), 4'h0);
        rst = 1'b0;

        // Config A: out0 combinational, out1 registered from feedback of out0.
        base_cfg();
        set_or(1, 2);
        set_mc(0, 1'b0, 1'b1);
        set_mc(1, 1'b1, 1'b1);
        load_cfg();
        begin
            logic prev = 1'b0;
            for (int m = 0; m < 8; m++) begin
                data_in = N_IN'(m);
                #4;
                check("R3 R4 R5 comb out0", 4'(pin_val[0]), 4'(fref(m)));
                check("R5 oe both", 4'(pin_oe), 4'h3);
                check("R6 out1 holds old", 4'(pin_val[1]), 4'(prev));
                @(posedge clk); #1;
                check("R6 feedback one cycle late", 4'(pin_val[1]), 4'(prev));
                @(posedge clk); #1;
                check("R6 feedback arrives", 4'(pin_val[1]), 4'(fref(m)));
                prev = fref(m);
            end
        end

        // Config B: out0 registered; out1 combinational on empty term P3.
        base_cfg();
        set_or(1, 3);
        set_mc(0, 1'b1, 1'b1);
        set_mc(1, 1'b0, 1'b1);
        load_cfg();
        begin
            logic prev = 1'b0; // R8: flip-flops leave programming cleared
            for (int m = 0; m < 8; m++) begin
                data_in = N_IN'(m);
                #4;
                check("R5 R8 registered out0 trails", 4'(pin_val[0]), 4'(prev));
                check("R3 empty term out1", 4'(pin_val[1]), 4'h0);
                @(posedge clk); #1;
                check("R5 registered out0", 4'(pin_val[0]), 4'(fref(m)));
                prev = fref(m);
            end
        end

        // Config C: as A but out0 disabled; feedback still runs.
        base_cfg();
        set_or(1, 2);
        set_mc(0, 1'b0, 1'b0);
        set_mc(1, 1'b1, 1'b1);
        load_cfg();
        for (int m = 0; m < 8; m++) begin
            data_in = N_IN'(m);
            #4;
            check("R7 disabled oe", 4'(pin_oe[0]), 4'h0);
            check("R7 disabled val", 4'(pin_val[0]), 4'h0);
            @(posedge clk); #1;
            @(posedge clk); #1;
            check("R7 feedback behind disabled pin", 4'(pin_val[1]), 4'(fref(m)));
        end

        // R1: reset wipes a loaded configuration.
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        data_in = '0;
        #4;
        check("R1 reset clears config oe", 4'(pin_oe), 4'h0);
        check("R1 reset clears config val", 4'(pin_val), 4'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule